// File: doc/BRIEF.md
# Serial Character Receiver with Sticky Status

The block takes an asynchronous serial line and turns each character on it into a byte in a holding register. Every character is framed by a low start bit and ends with a high stop bit. Eight data bits arrive least-significant bit first and may be followed by a parity bit. A baud tick at sixteen times the bit rate sets the timing. When the line falls, the block checks it again half a bit period later, so a short glitch cannot start a character. After that check, each later bit is sampled one full bit period after the previous one, which places every sample near the middle of its bit.

A host reads the byte from the holding register and raises a one-cycle read strobe. The strobe clears the ready flag. Two error flags stay set once raised, and only a one-cycle clear-status strobe resets them. The overrun flag means a character completed while the one before it was still unread. The parity-error flag means the received parity bit did not match the parity selected by the mode input. On overrun the newer character replaces the unread one.

Top module: `serial_rx_core`

## Requirements
- R1: Once a frame completes, `rx_data` holds its 8 data bits, with the first data bit after the start bit at bit 0.
- R2: `rx_ready` goes to 1 when a character completes. A `rd_strobe` pulse clears it unless a new character completes in the same cycle.
- R3: `par_mode` selects the parity rule: 0 even (the parity bit equals the XOR of the data bits), 1 odd (its inverse), 2 the parity bit is always 0, 3 the parity bit is always 1, 4 no parity.
- R4: If the received parity bit differs from the bit the R3 rule expects, `parity_err` goes to 1 in the same cycle that the character's `rx_ready` update happens.
- R5: `parity_err` stays at 1, even when later characters have correct parity, until a `clr_status` pulse.
- R6: If a character completes while `rx_ready` is still 1, `overrun` goes to 1. The new byte replaces the old one in `rx_data`, and `rx_ready` stays at 1.
- R7: `overrun` stays at 1, even across reads, until a `clr_status` pulse. That pulse also clears `parity_err`.
- R8: A low pulse on the line shorter than half a bit period (8 baud ticks) is ignored. No flag changes, and the next valid frame is received correctly.
- R9: After reset, `rx_ready`, `overrun` and `parity_err` are 0 and `rx_data` is 0.
- R10: With no parity selected, a frame is exactly start, 8 data and stop bits. A frame that follows immediately after the stop bit is still received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, high when idle |
| par_mode | input | 3 | Parity rule, encoded as in R3 |
| rd_strobe | input | 1 | Host read of the holding register |
| clr_status | input | 1 | Clears the overrun and parity-error flags |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | A character is waiting to be read |
| overrun | output | 1 | Sticky: a character completed while the previous one was unread |
| parity_err | output | 1 | Sticky: parity mismatch |

## Verification
A table of characters is sent in every parity rule, once with a correct parity bit and once with an inverted one. This shows whether the data is reassembled in the right bit order, and whether each rule predicts the right parity bit. The inverted-bit case in no-parity mode shows that no parity bit is expected and that no check is made. Two frames sent back to back without a read separate overrun from plain ready behaviour, and show that the flags persist across reads and good characters. A short low pulse on the line, followed by a real frame, separates glitch rejection from false starts.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        PAR_EVEN  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_SPACE = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_NONE  = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    // Parity bit the sender should have put on the line for the given data
    function automatic logic expect_parity(input logic [2:0] mode, input logic [7:0] d);
        case (mode)
            PAR_EVEN:  return ^d;
            PAR_ODD:   return ~(^d);
            PAR_SPACE: return 1'b0;
            PAR_MARK:  return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              line,
    input  logic [2:0]        mode,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              par_bad
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE/2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_W - 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              par_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            idx      <= '0;
            shreg    <= '0;
            par_seen <= 1'b0;
            done     <= 1'b0;
            data     <= '0;
            par_bad  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!line) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == HALF_LAST) begin
                            cnt <= '0;
                            idx <= '0;
                            state <= line ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == FULL_LAST) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[DATA_W-1:1]};
                            if (idx == IDX_LAST)
                                state <= (mode == PAR_NONE) ? ST_STOP : ST_PAR;
                            else
                                idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == FULL_LAST) begin
                            cnt      <= '0;
                            par_seen <= line;
                            state    <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == FULL_LAST) begin
                            cnt     <= '0;
                            done    <= 1'b1;
                            data    <= shreg;
                            par_bad <= (mode != PAR_NONE) &&
                                       (par_seen != expect_parity(mode, shreg));
                            state   <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_status.sv
module rx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [DATA_W-1:0] data_in,
    input  logic              par_bad,
    input  logic              rd_strobe,
    input  logic              clr_status,
    output logic [DATA_W-1:0] hold,
    output logic              ready,
    output logic              ovr,
    output logic              perr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold  <= '0;
            ready <= 1'b0;
            ovr   <= 1'b0;
            perr  <= 1'b0;
        end else begin
            if (done) begin
                hold  <= data_in;
                ready <= 1'b1;
            end else if (rd_strobe) begin
                ready <= 1'b0;
            end

            if (done && ready && !rd_strobe) ovr <= 1'b1;
            else if (clr_status)             ovr <= 1'b0;

            if (done && par_bad)   perr <= 1'b1;
            else if (clr_status)   perr <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVERSAMPLE = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              rx_line,
    input  logic [2:0]        par_mode,
    input  logic              rd_strobe,
    input  logic              clr_status,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              overrun,
    output logic              parity_err
);
    logic              line_s;
    logic              frm_done;
    logic [DATA_W-1:0] frm_data;
    logic              frm_par_bad;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(rx_line), .dout(line_s)
    );

    rx_framer #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_framer (
        .clk(clk), .rst(rst), .tick(baud_tick), .line(line_s), .mode(par_mode),
        .done(frm_done), .data(frm_data), .par_bad(frm_par_bad)
    );

    rx_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst(rst), .done(frm_done), .data_in(frm_data),
        .par_bad(frm_par_bad), .rd_strobe(rd_strobe), .clr_status(clr_status),
        .hold(rx_data), .ready(rx_ready), .ovr(overrun), .perr(parity_err)
    );
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk (
    input logic clk,
    input logic rst,
    input logic rd_strobe,
    input logic clr_status,
    input logic frm_done,
    input logic rx_ready,
    input logic overrun,
    input logic parity_err
);
    // R9
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!rx_ready && !overrun && !parity_err));

    // R2
    ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !frm_done) |=> !rx_ready);

    // R2
    ready_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ready) |-> $past(frm_done));

    // R4
    perr_timing_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(parity_err) |-> ($past(frm_done) && rx_ready));

    // R5
    perr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (parity_err && !clr_status) |=> parity_err);

    // R6
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_done && rx_ready && !rd_strobe) |=> (overrun && rx_ready));

    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overrun && !clr_status) |=> overrun);
endmodule

bind serial_rx_core serial_rx_chk u_chk (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .clr_status(clr_status),
    .frm_done(frm_done), .rx_ready(rx_ready), .overrun(overrun),
    .parity_err(parity_err)
);

// File: tb/test_serial_rx_core.sv
module test_serial_rx_core;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 32;   // 16 ticks, one tick every 2 clocks
    localparam int NVEC       = 10;

    logic       clk = 0;
    logic       rst = 1;
    logic       baud_tick = 0;
    logic       rx_line = 1;
    logic [2:0] par_mode = 3'd0;
    logic       rd_strobe = 0;
    logic       clr_status = 0;
    logic [7:0] rx_data;
    logic       rx_ready, overrun, parity_err;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    // {data, mode, corrupt parity}
    localparam logic [11:0] VEC [NVEC] = '{
        {8'hA5, 3'd0, 1'b0}, {8'h3C, 3'd0, 1'b1},
        {8'h01, 3'd1, 1'b0}, {8'hFE, 3'd1, 1'b1},
        {8'h80, 3'd2, 1'b0}, {8'h55, 3'd2, 1'b1},
        {8'h7F, 3'd3, 1'b0}, {8'h00, 3'd3, 1'b1},
        {8'hC3, 3'd4, 1'b0}, {8'h96, 3'd4, 1'b1}
    };

    serial_rx_core i_serial_rx_core (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rx_line(rx_line),
        .par_mode(par_mode), .rd_strobe(rd_strobe), .clr_status(clr_status),
        .rx_data(rx_data), .rx_ready(rx_ready), .overrun(overrun),
        .parity_err(parity_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) baud_tick <= ~baud_tick;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic ref_parity(input logic [2:0] m, input logic [7:0] d);
        logic x = 1'b0;
        for (int i = 0; i < 8; i++) x = x ^ d[i];
        case (m)
            3'd0: return x;
            3'd1: return !x;
            3'd2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic hold_bit(input logic b);
        rx_line = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic [2:0] m, input logic bad);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(d[i]);
        if (m != 3'd4) hold_bit(ref_parity(m, d) ^ bad);
        hold_bit(1'b1);
    endtask

    task automatic pulse_read;
        rd_strobe = 1; @(negedge clk); rd_strobe = 0; @(negedge clk);
    endtask

    task automatic pulse_clear;
        clr_status = 1; @(negedge clk); clr_status = 0; @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9 reset state
        check("R9 ready", {7'd0, rx_ready}, 8'd0);
        check("R9 overrun", {7'd0, overrun}, 8'd0);
        check("R9 parity_err", {7'd0, parity_err}, 8'd0);
        check("R9 data", rx_data, 8'h00);
        hold_bit(1'b1);

        // R1 R3 R4 R10: table of characters in every parity rule
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] d;
            logic [2:0] m;
            logic       bad;
            {d, m, bad} = VEC[v];
            par_mode = m;
            pulse_clear;
            pulse_read;
            send(d, m, bad);
            check("R1 data", rx_data, d);
            check("R2 ready", {7'd0, rx_ready}, 8'd1);
            check("R3/R4 parity_err", {7'd0, parity_err}, {7'd0, bad && (m != 3'd4)});
        end

        // R2 read clears ready
        pulse_read;
        check("R2 read clears ready", {7'd0, rx_ready}, 8'd0);

        // R6 R10 overrun with back-to-back frames, no parity
        par_mode = 3'd4;
        pulse_clear;
        send(8'h12, 3'd4, 1'b0);
        send(8'h34, 3'd4, 1'b0);
        check("R6 overrun", {7'd0, overrun}, 8'd1);
        check("R6 ready", {7'd0, rx_ready}, 8'd1);
        check("R10 R6 new data", rx_data, 8'h34);
        pulse_read;
        check("R7 overrun after read", {7'd0, overrun}, 8'd1);
        check("R2 ready after read", {7'd0, rx_ready}, 8'd0);
        pulse_clear;
        check("R7 overrun cleared", {7'd0, overrun}, 8'd0);

        // R5 sticky parity error across a good frame
        par_mode = 3'd0;
        send(8'h5A, 3'd0, 1'b1);
        check("R4 parity_err set", {7'd0, parity_err}, 8'd1);
        pulse_read;
        send(8'h5B, 3'd0, 1'b0);
        check("R5 parity_err sticky", {7'd0, parity_err}, 8'd1);
        check("R1 data after bad", rx_data, 8'h5B);
        check("R6 no overrun after read", {7'd0, overrun}, 8'd0);
        pulse_clear;
        check("R7 clear clears parity_err", {7'd0, parity_err}, 8'd0);
        pulse_read;

        // R8 glitch shorter than half a bit
        rx_line = 0;
        repeat (8) @(negedge clk);
        rx_line = 1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        check("R8 glitch ready", {7'd0, rx_ready}, 8'd0);
        check("R8 glitch parity_err", {7'd0, parity_err}, 8'd0);
        send(8'hE7, 3'd0, 1'b0);
        check("R8 frame after glitch", rx_data, 8'hE7);
        check("R8 ready after glitch", {7'd0, rx_ready}, 8'd1);

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule